// File: doc/BRIEF.md
# Serial NOR Page-Program Sequencer

This block writes a stream of bytes into a serial NOR flash without processor help. A client gives a start address, a byte count and a page size with a one-cycle start pulse. The block then takes the payload bytes from a valid/ready stream. For every page it runs a fixed series of chip-select windows. The first window is a write-enable command. The second is a page-program command carrying the address and the data. The third is a status read that keeps polling until the device reports it is no longer busy.

The flash is reached through a byte-level request port to an SPI shifter. Each accepted request either shifts out one byte or shifts in one byte. The shifter returns read bytes with a one-cycle valid strobe. The chip select is driven by the block itself. Its falling edge marks the end of every command.

Page splitting is automatic. A program window never crosses a multiple of the page size. The next window after it picks up at the following address.

Top module: `spi_pgm_seq`

## Requirements
- R1: A write-enable window holds exactly one transferred byte, opcode 0x06, and chip select drops in the cycle after that byte is accepted.
- R2: A program window carries opcode 0x02, then the address in three bytes with the most significant byte first, then the payload bytes in stream order, all under one chip-select assertion.
- R3: The first page boundary is the smallest multiple of the effective page size that is strictly above the start address.
- R4: A program window stops after the byte that brings the address to the current page boundary, or after the last counted byte, whichever comes first. The boundary then moves up by one page size.
- R5: After each program window, a status window sends opcode 0x05 and then issues read requests back to back. The window ends at the first returned byte whose bit 0 is 0. Bits 7..1 of the returned byte are ignored.
- R6: When bytes remain after a status window, the next window is a write enable. Otherwise `done` is high for exactly one cycle and `busy` falls.
- R7: The address in each program window equals the start address plus the number of payload bytes already sent.
- R8: `in_ready` is high only during the payload phase of a program window. Every one of the counted bytes is consumed.
- R9: A start with a count of zero opens no chip-select window, and `done` is high in the cycle after the start pulse.
- R10: A page size that is a power of two from 16 to 4096 is used as given. Any other value is replaced by 256.
- R11: A start pulse while `busy` is high has no effect on the running sequence.
- R12: Chip select is low for at least one cycle between windows. A job of P pages produces exactly 3·P windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle job request, taken only when idle |
| start_addr | input | AW | Flash byte address of the first payload byte |
| byte_cnt | input | CW | Number of payload bytes |
| page_size | input | PSW | Requested page size in bytes |
| in_valid | input | 1 | Payload byte available |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Payload byte taken this cycle |
| cs_active | output | 1 | Flash chip select, high while a window is open |
| op_valid | output | 1 | Byte request to the shifter |
| op_read | output | 1 | Request is a read (1) or a write of `op_data` (0) |
| op_data | output | 8 | Byte to shift out |
| op_ready | input | 1 | Shifter accepts the request |
| rd_valid | input | 1 | Read byte returned by the shifter |
| rd_data | input | 8 | Returned byte, bit 0 is the busy flag |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
The assertions cover the properties that hold cycle by cycle. These are the gating of `in_ready` to the payload phase, and that no accepted payload byte reaches the page boundary. They also check the alignment and power-of-two shape of the effective page size, the one-byte write-enable window, the address step per byte, the open window during a busy poll, and the one-cycle done pulse. The bench scoreboard shows the rest, because those properties need the whole job in view. That covers the exact byte content of every window, the split points for awkward start addresses and clamped page sizes, and the number of status polls that match the simulated device busy time. It also covers that a start request sent in mid-job leaves the sequence unchanged.

// File: rtl/spi_pgm_pkg.sv
package spi_pgm_pkg;

  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_PROG = 8'h02;

  localparam int unsigned PS_MIN = 16;
  localparam int unsigned PS_MAX = 4096;
  localparam int unsigned PS_DEF = 256;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WREN,
    S_WREN_END,
    S_PP_CMD,
    S_PP_ADDR,
    S_PP_DATA,
    S_PP_END,
    S_RS_CMD,
    S_RS_RD,
    S_RS_WAIT,
    S_RS_END,
    S_DONE
  } seq_state_t;

  // Legal page sizes are single-bit values inside [PS_MIN, PS_MAX].
  function automatic logic [31:0] page_size_sane(input logic [31:0] req);
    logic legal;
    legal = (req >= PS_MIN) && (req <= PS_MAX) && ((req & (req - 32'd1)) == 32'd0);
    return legal ? req : 32'(PS_DEF);
  endfunction

  // Boundary strictly above addr: round down to the page base, add one page.
  function automatic logic [31:0] first_page_end(input logic [31:0] addr,
                                                 input logic [31:0] ps);
    return (addr & ~(ps - 32'd1)) + ps;
  endfunction

endpackage

// File: rtl/pgm_addr_unit.sv
module pgm_addr_unit
  import spi_pgm_pkg::*;
#(
  parameter int AW  = 24,
  parameter int CW  = 16,
  parameter int PSW = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [AW-1:0]  ld_addr,
  input  logic [CW-1:0]  ld_cnt,
  input  logic [PSW-1:0] ld_ps,
  input  logic           byte_adv,
  input  logic           page_adv,
  output logic [AW-1:0]  cur_addr,
  output logic [AW:0]    page_end,
  output logic [CW-1:0]  remaining,
  output logic [PSW-1:0] ps_eff,
  output logic           page_last,
  output logic           cnt_last,
  output logic           cnt_zero
);

  logic [PSW-1:0] ps_new;
  logic [AW:0]    pe_new;

  always_comb begin
    ps_new = PSW'(page_size_sane(32'(ld_ps)));
    pe_new = (AW+1)'(first_page_end(32'(ld_addr), 32'(ps_new)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      page_end  <= '0;
      remaining <= '0;
      ps_eff    <= PSW'(PS_DEF);
    end else if (load) begin
      cur_addr  <= ld_addr;
      page_end  <= pe_new;
      remaining <= ld_cnt;
      ps_eff    <= ps_new;
    end else begin
      if (byte_adv) begin
        cur_addr  <= cur_addr + 1'b1;
        remaining <= remaining - 1'b1;
      end
      if (page_adv) begin
        page_end <= page_end + (AW+1)'(ps_eff);
      end
    end
  end

  assign page_last = (({1'b0, cur_addr}) + 1'b1) == page_end;
  assign cnt_last  = remaining == CW'(1);
  assign cnt_zero  = remaining == '0;

endmodule

// File: rtl/pgm_seq_fsm.sv
module pgm_seq_fsm
  import spi_pgm_pkg::*;
#(
  parameter int ABYTES = 3,
  localparam int AIW   = (ABYTES > 1) ? $clog2(ABYTES) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           cnt_in_zero,
  input  logic           op_fire,
  input  logic           rd_valid,
  input  logic           rd_busy,
  input  logic           page_last,
  input  logic           cnt_last,
  input  logic           cnt_zero,
  output seq_state_t     state,
  output logic [AIW-1:0] aidx,
  output logic           load,
  output logic           byte_adv,
  output logic           page_adv
);

  seq_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:     if (start) nxt = cnt_in_zero ? S_DONE : S_WREN;
      S_WREN:     if (op_fire) nxt = S_WREN_END;
      S_WREN_END: nxt = S_PP_CMD;
      S_PP_CMD:   if (op_fire) nxt = S_PP_ADDR;
      S_PP_ADDR:  if (op_fire && aidx == AIW'(ABYTES - 1)) nxt = S_PP_DATA;
      S_PP_DATA:  if (op_fire && (page_last || cnt_last)) nxt = S_PP_END;
      S_PP_END:   nxt = S_RS_CMD;
      S_RS_CMD:   if (op_fire) nxt = S_RS_RD;
      S_RS_RD:    if (op_fire) nxt = S_RS_WAIT;
      S_RS_WAIT:  if (rd_valid) nxt = rd_busy ? S_RS_RD : S_RS_END;
      S_RS_END:   nxt = cnt_zero ? S_DONE : S_WREN;
      S_DONE:     nxt = S_IDLE;
      default:    nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      aidx  <= '0;
    end else begin
      state <= nxt;
      if (state == S_PP_CMD) aidx <= '0;
      else if (state == S_PP_ADDR && op_fire) aidx <= aidx + 1'b1;
    end
  end

  assign load     = (state == S_IDLE) && start;
  assign byte_adv = (state == S_PP_DATA) && op_fire;
  assign page_adv = (state == S_PP_END);

endmodule

// File: rtl/spi_pgm_seq.sv
module spi_pgm_seq
  import spi_pgm_pkg::*;
#(
  parameter int AW  = 24,
  parameter int CW  = 16,
  parameter int PSW = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  start_addr,
  input  logic [CW-1:0]  byte_cnt,
  input  logic [PSW-1:0] page_size,
  input  logic           in_valid,
  input  logic [7:0]     in_data,
  output logic           in_ready,
  output logic           cs_active,
  output logic           op_valid,
  output logic           op_read,
  output logic [7:0]     op_data,
  input  logic           op_ready,
  input  logic           rd_valid,
  input  logic [7:0]     rd_data,
  output logic           busy,
  output logic           done
);

  localparam int ABYTES = (AW + 7) / 8;
  localparam int AIW    = (ABYTES > 1) ? $clog2(ABYTES) : 1;
  localparam int AXW    = 8 * ABYTES;

  seq_state_t     state;
  logic [AIW-1:0] aidx;
  logic           load, byte_adv, page_adv;
  logic [AW-1:0]  cur_addr;
  logic [AW:0]    page_end;
  logic [CW-1:0]  remaining;
  logic [PSW-1:0] ps_eff;
  logic           page_last, cnt_last, cnt_zero;

  // Named internal events for the checker.
  logic           op_fire, byte_fire, addr_phase, data_phase, status_busy;
  logic [AXW-1:0] addr_ext;
  logic [7:0]     addr_byte;

  assign status_busy = rd_data[0];
  assign addr_phase  = (state == S_PP_ADDR);
  assign data_phase  = (state == S_PP_DATA);
  assign op_fire     = op_valid && op_ready;
  assign byte_fire   = data_phase && op_fire;
  assign addr_ext    = AXW'(cur_addr);
  assign addr_byte   = addr_ext[8*(ABYTES-1-int'(aidx)) +: 8];

  pgm_addr_unit #(.AW(AW), .CW(CW), .PSW(PSW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .ld_addr   (start_addr),
    .ld_cnt    (byte_cnt),
    .ld_ps     (page_size),
    .byte_adv  (byte_adv),
    .page_adv  (page_adv),
    .cur_addr  (cur_addr),
    .page_end  (page_end),
    .remaining (remaining),
    .ps_eff    (ps_eff),
    .page_last (page_last),
    .cnt_last  (cnt_last),
    .cnt_zero  (cnt_zero)
  );

  pgm_seq_fsm #(.ABYTES(ABYTES)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cnt_in_zero (byte_cnt == '0),
    .op_fire     (op_fire),
    .rd_valid    (rd_valid),
    .rd_busy     (status_busy),
    .page_last   (page_last),
    .cnt_last    (cnt_last),
    .cnt_zero    (cnt_zero),
    .state       (state),
    .aidx        (aidx),
    .load        (load),
    .byte_adv    (byte_adv),
    .page_adv    (page_adv)
  );

  always_comb begin
    cs_active = 1'b0;
    op_valid  = 1'b0;
    op_read   = 1'b0;
    op_data   = 8'h00;
    unique case (state)
      S_WREN:    begin cs_active = 1'b1; op_valid = 1'b1; op_data = OPC_WREN; end
      S_PP_CMD:  begin cs_active = 1'b1; op_valid = 1'b1; op_data = OPC_PROG; end
      S_PP_ADDR: begin cs_active = 1'b1; op_valid = 1'b1; op_data = addr_byte; end
      S_PP_DATA: begin cs_active = 1'b1; op_valid = in_valid; op_data = in_data; end
      S_RS_CMD:  begin cs_active = 1'b1; op_valid = 1'b1; op_data = OPC_RDSR; end
      S_RS_RD:   begin cs_active = 1'b1; op_valid = 1'b1; op_read = 1'b1; end
      S_RS_WAIT: begin cs_active = 1'b1; end
      default:   ;
    endcase
  end

  assign in_ready = data_phase && op_ready;
  assign busy     = (state != S_IDLE);
  assign done     = (state == S_DONE);

endmodule

// File: rtl/pgm_seq_chk.sv
module pgm_seq_chk
  import spi_pgm_pkg::*;
#(
  parameter int AW  = 24,
  parameter int CW  = 16,
  parameter int PSW = 13
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [CW-1:0]  byte_cnt,
  input logic           in_ready,
  input logic           cs_active,
  input logic           op_valid,
  input logic           op_ready,
  input logic           op_read,
  input logic [7:0]     op_data,
  input logic           rd_valid,
  input logic [7:0]     rd_data,
  input logic           busy,
  input logic           done,
  input logic           byte_fire,
  input logic           addr_phase,
  input logic           data_phase,
  input logic [AW-1:0]  cur_addr,
  input logic [AW:0]    page_end,
  input logic [PSW-1:0] ps_eff
);

  logic [PSW-1:0] ps_mask;
  assign ps_mask = ps_eff - 1'b1;

  AST_READY_ONLY_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (data_phase && cs_active)); // R8

  AST_BYTE_BELOW_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    byte_fire |-> ({1'b0, cur_addr} < page_end)); // R4

  AST_BOUNDARY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((page_end[PSW-1:0] & ps_mask) == '0)); // R3

  AST_PAGE_SIZE_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ps_eff) == 1); // R10

  AST_WREN_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && !op_read && !addr_phase && !data_phase && op_data == OPC_WREN)
      |=> !cs_active); // R1

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_fire |=> (cur_addr == AW'($past(cur_addr) + 1'b1))); // R7

  AST_POLL_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && rd_valid && rd_data[0]) |=> cs_active); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_ZERO_COUNT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && byte_cnt == '0) |=> (done && !cs_active)); // R9

endmodule

bind spi_pgm_seq pgm_seq_chk #(.AW(AW), .CW(CW), .PSW(PSW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .byte_cnt   (byte_cnt),
  .in_ready   (in_ready),
  .cs_active  (cs_active),
  .op_valid   (op_valid),
  .op_ready   (op_ready),
  .op_read    (op_read),
  .op_data    (op_data),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .busy       (busy),
  .done       (done),
  .byte_fire  (byte_fire),
  .addr_phase (addr_phase),
  .data_phase (data_phase),
  .cur_addr   (cur_addr),
  .page_end   (page_end),
  .ps_eff     (ps_eff)
);

// File: tb/spi_pgm_seq_tb.sv
module spi_pgm_seq_tb;
  localparam int AW = 24, CW = 16, PSW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic           start = 1'b0;
  logic [AW-1:0]  start_addr = '0;
  logic [CW-1:0]  byte_cnt = '0;
  logic [PSW-1:0] page_size = '0;
  logic           in_valid = 1'b0;
  logic [7:0]     in_data = 8'h00;
  logic           in_ready, cs_active, op_valid, op_read, busy, done;
  logic [7:0]     op_data;
  logic           op_ready = 1'b0;
  logic           rd_valid = 1'b0;
  logic [7:0]     rd_data = 8'h00;

  spi_pgm_seq #(.AW(AW), .CW(CW), .PSW(PSW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_cnt(byte_cnt), .page_size(page_size), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .cs_active(cs_active),
    .op_valid(op_valid), .op_read(op_read), .op_data(op_data),
    .op_ready(op_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .done(done)
  );

  int n_checks = 0, n_fail = 0;
  logic [7:0] dbytes [0:4095];
  logic [8:0] win [0:4199];
  int n_total = 0, src_idx = 0, win_len = 0, win_count = 0;
  int exp_a, exp_rem, exp_pe, exp_ps, exp_di, exp_kind = 3, first_pp_len;
  int busy_left = 0, busy_set = 0, done_seen = 0, r8_bad = 0;
  bit pend_in = 0, pend_rd = 0, prev_cs = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int bench_ps(input int req);
    for (int p = 16; p <= 4096; p = p * 2) if (req == p) return p;
    return 256;
  endfunction

  task automatic check_window();
    int k, bad, reads, addr_got;
    if (exp_kind == 0) begin
      chk(win_len == 1 && win[0] == 9'h006, "R1", "write-enable window (len/byte0)",
          win_len * 1000 + int'(win[0]), 1006);
      exp_kind = 1;
    end else if (exp_kind == 1) begin
      k = (exp_rem < exp_pe - exp_a) ? exp_rem : exp_pe - exp_a;
      chk(win_len >= 4 && win[0] == 9'h002, "R2", "program opcode", int'(win[0]), 2);
      addr_got = {win[1][7:0], win[2][7:0], win[3][7:0]};
      chk(addr_got == exp_a, "R7", "program address", addr_got, exp_a);
      chk(win_len == 4 + k, "R4", "program window length", win_len, 4 + k);
      bad = 0;
      for (int i = 0; i < k && 4 + i < win_len; i++)
        if (win[4 + i] != {1'b0, dbytes[exp_di + i]}) bad++;
      chk(bad == 0, "R2", "payload byte mismatches", bad, 0);
      if (first_pp_len < 0) first_pp_len = win_len - 4;
      exp_a += k; exp_di += k; exp_rem -= k; exp_pe += exp_ps;
      busy_set = $urandom % 4;
      busy_left = busy_set;
      exp_kind = 2;
    end else if (exp_kind == 2) begin
      reads = 0;
      for (int i = 1; i < win_len; i++) if (win[i][8]) reads++;
      chk(win_len >= 1 && win[0] == 9'h005 && reads == win_len - 1, "R5",
          "status window form", int'(win[0]), 5);
      chk(reads == busy_set + 1, "R5", "status poll reads", reads, busy_set + 1);
      exp_kind = (exp_rem != 0) ? 0 : 3;
    end else begin
      chk(0, "R6", "window after job end", win_len, 0);
    end
    win_count++;
  endtask

  // Monitor: values at a falling edge are those sampled at the next rising edge.
  always @(negedge clk) begin
    pend_in = 0;
    pend_rd = 0;
    if (rst_n) begin
      pend_in = in_valid && in_ready;
      pend_rd = op_valid && op_ready && op_read;
      if (done) done_seen++;
      if (in_ready && (!cs_active || exp_kind != 1 || win_len < 4)) r8_bad++;
      if (cs_active && !prev_cs) win_len = 0;
      if (op_valid && op_ready && win_len < 4200) begin
        win[win_len] = {op_read, op_data};
        win_len++;
      end
      if (!cs_active && prev_cs) check_window();
      prev_cs = cs_active;
    end
  end

  // Shifter, flash busy and payload source model.
  always @(posedge clk) begin
    if (!rst_n) begin
      op_ready <= 1'b0;
      rd_valid <= 1'b0;
      in_valid <= 1'b0;
    end else begin
      if (pend_in) src_idx++;
      in_valid <= (src_idx < n_total) && ($urandom % 5 != 0);
      in_data  <= dbytes[src_idx % 4096];
      op_ready <= ($urandom % 4 != 0);
      rd_valid <= pend_rd;
      if (pend_rd) begin
        rd_data <= {7'($urandom), busy_left != 0};
        if (busy_left != 0) busy_left--;
      end
    end
  end

  task automatic run_job(input int a, input int n, input int psr, input bit inject,
                         input string tag);
    int ps, pe, ad, rem, pages, wc0, cyc, first_exp;
    ps = bench_ps(psr);
    for (int i = 0; i < n; i++) dbytes[i] = 8'($urandom);
    n_total = n; src_idx = 0;
    exp_a = a; exp_rem = n; exp_ps = ps; exp_pe = (a / ps + 1) * ps; exp_di = 0;
    exp_kind = (n == 0) ? 3 : 0; first_pp_len = -1; done_seen = 0; r8_bad = 0;
    first_exp = (n < exp_pe - a) ? n : exp_pe - a;
    rem = n; ad = a; pe = exp_pe; pages = 0;
    while (rem > 0) begin
      int k;
      k = (rem < pe - ad) ? rem : pe - ad;
      rem -= k; ad += k; pe += ps; pages++;
    end
    wc0 = win_count;
    start = 1'b1; start_addr = AW'(a); byte_cnt = CW'(n); page_size = PSW'(psr);
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      chk(done === 1'b1, "R9", "done after zero-count start", done, 1);
      @(negedge clk);
      chk(done === 1'b0 && busy === 1'b0, "R6", "done single cycle", done, 0);
      repeat (3) @(negedge clk);
    end else begin
      if (inject) begin
        repeat (5) @(negedge clk);
        start = 1'b1; start_addr = AW'(a + 7); byte_cnt = CW'(3); page_size = PSW'(16);
        @(negedge clk);
        start = 1'b0;
      end
      cyc = 0;
      while (done_seen == 0 && cyc < 60000) begin
        @(negedge clk);
        cyc++;
      end
      if (cyc >= 60000) chk(0, "R6", "watchdog expired waiting for done", cyc, 0);
      repeat (2) @(negedge clk);
      chk(done_seen == 1, "R6", "done pulses", done_seen, 1);
      chk(exp_kind == 3, "R6", "sequence reached end", exp_kind, 3);
      chk(busy === 1'b0, "R6", "busy after job", busy, 0);
      chk(src_idx == n, "R8", "payload bytes consumed", src_idx, n);
      chk(first_pp_len == first_exp, tag, "first program length", first_pp_len, first_exp);
      if (inject) chk(done_seen == 1 && exp_kind == 3, "R11", "start while busy ignored",
                      done_seen, 1);
    end
    chk(r8_bad == 0, "R8", "in_ready outside payload phase", r8_bad, 0);
    chk(win_count - wc0 == 3 * pages, "R12", "window count", win_count - wc0, 3 * pages);
  endtask

  initial begin
    void'($urandom(32'd20240917));
    repeat (4) @(negedge clk);
    chk(in_ready === 1'b0, "R8", "in_ready in reset", in_ready, 0);
    chk(cs_active === 1'b0 && busy === 1'b0 && done === 1'b0, "R12",
        "idle outputs in reset", {cs_active, busy, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_job(256, 40, 256, 0, "R3");
    run_job(255, 1, 256, 0, "R3");
    run_job(4090, 20, 4096, 0, "R3");
    run_job(32, 48, 16, 0, "R4");
    run_job(250, 20, 100, 0, "R10");
    run_job(1000, 70, 8, 0, "R10");
    run_job(5, 40, 5000, 0, "R10");
    run_job(77, 0, 256, 0, "R9");
    run_job(300, 500, 64, 1, "R3");
    for (int j = 0; j < 10; j++) begin
      int a, n, psr;
      a = $urandom % (1 << 20);
      n = 1 + $urandom % 600;
      psr = ($urandom % 4 == 0) ? $urandom % 5000 : (16 << ($urandom % 9));
      run_job(a, n, psr, 0, "R3");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule